// File: doc/BRIEF.md
# Slot-Timed Shared Memory Arbiter

This block shares one memory between a fixed DMA schedule and a single CPU. Time is cut into memory slots of two clocks each. At the first clock of every slot the arbiter settles who owns it: a slot the DMA schedule has reserved goes to DMA. A free slot goes to a waiting CPU request unless the CPU owned the slot just before. The owner, address and direction are then frozen for the rest of the slot.

The CPU presents its request when it is ready for the data phase of its bus cycle, and holds it until it sees the acknowledge. Requests are looked at only at slot boundaries, so a CPU transfer never straddles two slots and any wait is a whole number of slots. The DMA scheduler drives a reservation and its address for the coming slot. It uses the slot number output to track its timetable.

Top module: `slot_arbiter`

## Requirements
- R1: A slot lasts exactly two clocks. `slot_num` holds for both clocks of a slot and advances by one (modulo 2^SLOT_W) at each slot start.
- R2: Owner, `mem_ras`, `mem_cpu`, `mem_addr` and `mem_we` are decided at the slot start and do not change during the second clock of the slot.
- R3: If `dma_rsv` is high at a slot boundary, that slot goes to DMA (`mem_ras`=1, `mem_cpu`=0, `mem_addr`=`dma_addr`, `mem_we`=`dma_we`) and the CPU gets nothing in it.
- R4: A CPU request is considered only at slot boundaries. A request raised in the first clock of a free slot is not served in that slot; it is served in the next one.
- R5: The CPU is never granted two consecutive slots. With no reservations, a CPU that requests without pause is acknowledged in every second slot.
- R6: `cpu_ack` is high only in the second clock of a CPU-owned slot. In that clock `cpu_rdata` equals `mem_rdata`.
- R7: For a CPU write, `mem_we`=1 throughout the slot. `mem_wdata` in the second clock holds `cpu_wdata` as captured during the first clock.
- R8: After reset the block is in the first clock of slot 0, with `slot_num`=0, `mem_ras`=0, `mem_cpu`=0 and `cpu_ack`=0.
- R9: A CPU request blocked by a reserved slot is served in the next free slot that does not follow a CPU slot. This holds for both even and odd slot numbers.
- R10: A slot with neither a reservation nor an eligible CPU request is idle, with `mem_ras`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU ready for its data transfer; held until acknowledged |
| cpu_addr | input | AW | CPU word address |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | Data acknowledge, second clock of a CPU slot |
| dma_rsv | input | 1 | The coming slot is reserved for DMA |
| dma_addr | input | AW | DMA address for the coming slot |
| dma_we | input | 1 | DMA direction for the coming slot |
| slot_num | output | SLOT_W | Number of the current slot |
| mem_ras | output | 1 | Row strobe, high for the whole of an owned slot |
| mem_cpu | output | 1 | Current slot belongs to the CPU |
| mem_addr | output | AW | Memory address for the current slot |
| mem_we | output | 1 | Memory write for the current slot |
| mem_wdata | output | DW | CPU write data to memory |
| mem_rdata | input | DW | Data read from memory |

## Verification
The bench builds the arbiter with AW=8, DW=8 and SLOT_W=3. The narrow slot counter wraps from 7 to 0 in a few slots, so the R1 wrap check fits into a short run. The 8-bit memory model returns a read value derived from the address, so each acknowledged read can be matched to the address the slot latched. These sizes leave room for the ownership patterns: requests raised in either clock of a slot, DMA-then-CPU, CPU-DMA-CPU, and a CPU that never releases its request.

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ack,
  input  logic              dma_rsv,
  input  logic [AW-1:0]     dma_addr,
  input  logic              dma_we,
  output logic [SLOT_W-1:0] slot_num,
  output logic              mem_ras,
  output logic              mem_cpu,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);

  logic              phase;
  logic [SLOT_W-1:0] slot_q;
  logic              own_cpu;
  logic              own_dma;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;

  wire boundary = phase;
  wire take_cpu = cpu_req && !dma_rsv && !own_cpu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      slot_q  <= '0;
      own_cpu <= 1'b0;
      own_dma <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      phase <= ~phase;
      if (boundary) begin
        slot_q  <= slot_q + 1'b1;
        own_dma <= dma_rsv;
        own_cpu <= take_cpu;
        addr_q  <= dma_rsv ? dma_addr : (take_cpu ? cpu_addr : '0);
        we_q    <= dma_rsv ? dma_we : (take_cpu && cpu_we);
      end
      if (!phase && own_cpu && we_q)
        wdata_q <= cpu_wdata;
    end
  end

  assign slot_num  = slot_q;
  assign mem_ras   = own_cpu | own_dma;
  assign mem_cpu   = own_cpu;
  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign cpu_ack   = own_cpu && phase;
  assign cpu_rdata = cpu_ack ? mem_rdata : '0;

  AST_HOLD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> ($stable(mem_addr) && $stable(mem_ras) && $stable(mem_cpu) && $stable(mem_we))); // R2

  AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && dma_rsv) |=> (mem_ras && !mem_cpu)); // R3

  AST_CPU_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (!$past(dma_rsv, 2) && $past(cpu_req, 2))); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack ##1 !cpu_ack ##1 !cpu_ack); // R5

  AST_ACK_SECOND_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (mem_cpu && $past(mem_cpu) && !$past(cpu_ack))); // R6

endmodule

// File: tb/slot_arbiter_bench.sv
module slot_arbiter_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_we = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_ack;
  logic dma_rsv = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic dma_we = 1'b0;
  logic [SW-1:0] slot_num;
  logic mem_ras, mem_cpu, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int total = 0;
  int bad = 0;
  int wd = 0;
  logic bp = 1'b0;

  always #10 clk = ~clk;

  assign mem_rdata = mem_addr ^ 8'hA5;

  slot_arbiter #(.AW(AW), .DW(DW), .SLOT_W(SW)) u_slot_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .dma_rsv(dma_rsv), .dma_addr(dma_addr), .dma_we(dma_we),
    .slot_num(slot_num),
    .mem_ras(mem_ras), .mem_cpu(mem_cpu), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) bp <= rst_n ? ~bp : 1'b0;

  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=%0d expected<=%0d", wd, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input logic p);
    @(negedge clk);
    while (bp != p) @(negedge clk);
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) begin
      wait_phase(1'b0);
      chk("R10 idle ras", int'(mem_ras), 0);
    end
  endtask

  task automatic t_reset;
    chk("R8 slot_num", int'(slot_num), 0);
    chk("R8 ras", int'(mem_ras), 0);
    chk("R8 mem_cpu", int'(mem_cpu), 0);
    chk("R8 ack", int'(cpu_ack), 0);
  endtask

  task automatic t_slot_count;
    logic [SW-1:0] prev;
    wait_phase(1'b0);
    prev = slot_num;
    for (int i = 0; i < 10; i++) begin
      wait_phase(1'b1);
      chk("R1 hold in slot", int'(slot_num), int'(prev));
      wait_phase(1'b0);
      chk("R1 advance", int'(slot_num), int'(SW'(prev + 1'b1)));
      prev = slot_num;
    end
  endtask

  task automatic t_read;
    wait_phase(1'b1);
    cpu_req = 1'b1; cpu_addr = 8'h3C; cpu_we = 1'b0;
    wait_phase(1'b0);
    chk("R2 ras", int'(mem_ras), 1);
    chk("R2 owner", int'(mem_cpu), 1);
    chk("R2 addr", int'(mem_addr), 'h3C);
    chk("R6 no ack first clock", int'(cpu_ack), 0);
    cpu_addr = 8'hFF;
    wait_phase(1'b1);
    chk("R2 addr held", int'(mem_addr), 'h3C);
    chk("R6 ack", int'(cpu_ack), 1);
    chk("R6 rdata", int'(cpu_rdata), 'h3C ^ 'hA5);
    cpu_req = 1'b0;
    idle_slots(2);
  endtask

  task automatic t_mid_slot;
    wait_phase(1'b0);
    cpu_req = 1'b1; cpu_addr = 8'h11; cpu_we = 1'b0;
    wait_phase(1'b1);
    chk("R4 not served mid slot", int'(cpu_ack), 0);
    chk("R4 slot stays idle", int'(mem_ras), 0);
    wait_phase(1'b0);
    chk("R4 owner next slot", int'(mem_cpu), 1);
    wait_phase(1'b1);
    chk("R4 ack next slot", int'(cpu_ack), 1);
    cpu_req = 1'b0;
    idle_slots(2);
  endtask

  task automatic t_write;
    wait_phase(1'b1);
    cpu_req = 1'b1; cpu_addr = 8'h42; cpu_we = 1'b1; cpu_wdata = 8'h9D;
    wait_phase(1'b0);
    chk("R7 we first clock", int'(mem_we), 1);
    wait_phase(1'b1);
    chk("R7 wdata", int'(mem_wdata), 'h9D);
    chk("R7 we second clock", int'(mem_we), 1);
    chk("R6 write ack", int'(cpu_ack), 1);
    cpu_wdata = 8'h00;
    cpu_req = 1'b0; cpu_we = 1'b0;
    idle_slots(2);
  endtask

  task automatic t_dma_block;
    wait_phase(1'b1);
    cpu_req = 1'b1; cpu_addr = 8'h20; cpu_we = 1'b0;
    dma_rsv = 1'b1; dma_addr = 8'h77; dma_we = 1'b1;
    wait_phase(1'b0);
    chk("R3 ras", int'(mem_ras), 1);
    chk("R3 not cpu", int'(mem_cpu), 0);
    chk("R3 dma addr", int'(mem_addr), 'h77);
    chk("R3 dma we", int'(mem_we), 1);
    wait_phase(1'b1);
    chk("R3 no ack", int'(cpu_ack), 0);
    dma_rsv = 1'b0; dma_we = 1'b0;
    wait_phase(1'b0);
    chk("R9 cpu next slot", int'(mem_cpu), 1);
    chk("R9 cpu addr", int'(mem_addr), 'h20);
    wait_phase(1'b1);
    chk("R9 ack after one slot", int'(cpu_ack), 1);
    cpu_req = 1'b0;
    idle_slots(2);
  endtask

  task automatic t_continuous;
    int acks;
    acks = 0;
    wait_phase(1'b1);
    cpu_req = 1'b1; cpu_addr = 8'h05;
    for (int i = 0; i < 6; i++) begin
      wait_phase(1'b1);
      chk("R5 alternate", int'(cpu_ack), (i % 2 == 0) ? 1 : 0);
      if (cpu_ack) acks++;
    end
    cpu_req = 1'b0;
    chk("R5 every second slot", acks, 3);
    idle_slots(2);
  endtask

  task automatic t_dma_pattern;
    wait_phase(1'b1);
    cpu_req = 1'b1; cpu_addr = 8'h0A; dma_addr = 8'h60;
    for (int i = 0; i < 4; i++) begin
      dma_rsv = (i % 2 == 0);
      wait_phase(1'b0);
      chk("R9 owner pattern", int'(mem_cpu), (i % 2 == 1) ? 1 : 0);
      wait_phase(1'b1);
      chk("R9 ack pattern", int'(cpu_ack), (i % 2 == 1) ? 1 : 0);
    end
    dma_rsv = 1'b0;
    cpu_req = 1'b0;
    idle_slots(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_slot_count();
    t_read();
    t_mid_slot();
    t_write();
    t_dma_block();
    t_continuous();
    t_dma_pattern();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule